// File: doc/BRIEF.md
# Tiled Matrix Transpose Engine

This block transposes a matrix of 32-bit words held in an external source memory and writes the result into an external destination memory. The matrix width and height are supplied at run time. The work is done in square tiles of 32 by 32 elements, one tile at a time, through an on-chip tile buffer. For each tile, a fill pass reads the source words at consecutive addresses, row by row. Then a drain pass writes the tile out as consecutive rows of the transposed matrix. Both the reads and the writes therefore run at unit stride.

A single-cycle start pulse captures the width, the height and both base addresses. The engine then walks the source tiles in row-major order of tile index. When a tile lies on the right or bottom edge of the matrix, the elements that fall outside the matrix are passed over with no memory beat. After the last write of the last tile, the engine raises a one-cycle done pulse. Both memory ports use a valid/ready handshake that moves one word per accepted beat. The read data must be valid in the same cycle as the read address.

Top module: `tile_transpose_engine`

## Requirements
- R1: After reset, the outputs busy, done, rd_valid and wr_valid are all low.
- R2: In the fill pass, the source element at row y and column x is read at address src_base + y*width + x. Within a tile, reads go row by row with the column incrementing fastest. No read beat is issued when x >= width or y >= height.
- R3: In the drain pass of the tile at tile row tr and tile column tc, destination element (y, x) is written. Here y = tc*32 + j and x = tr*32 + i, with j outer and i inner. The address is dst_base + y*height + x. The data is the source element at row x, column y. No write beat is issued when x >= height or y >= width.
- R4: The first write of a tile occurs only after every read of that tile has been accepted. The next tile's first read occurs only after every write of the current tile. rd_valid and wr_valid are never high together.
- R5: Source tiles are processed in row-major order of tile index: tile column fastest, then tile row.
- R6: While a valid is high and ready is low, the valid stays high and the address (and the write data) stays unchanged.
- R7: After the final write of a transpose, done is high for exactly one cycle and busy is low from the following cycle onward.
- R8: start is acted on only while the engine is idle. A start pulse or changed configuration inputs during a run have no effect on that run.
- R9: A start with width or height equal to zero produces a done pulse with no memory beats.
- R10: rd_valid and wr_valid are low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transpose (acted on while idle) |
| cfg_width | input | DIM_W | Source columns |
| cfg_height | input | DIM_W | Source rows |
| cfg_src_base | input | ADDR_W | Source base word address |
| cfg_dst_base | input | ADDR_W | Destination base word address |
| busy | output | 1 | Fill or drain in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read word address |
| rd_data | input | DATA_W | Read word, valid with rd_addr |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | DATA_W | Write word |

## Verification
Some properties are checked every cycle by the assertions. These are: handshake holding on both ports, the one-cycle done pulse, read and write never overlapping, silence while idle, and every read address lying inside the source matrix. The bench's scenarios are needed to show the rest. That covers the exact order of reads and writes, the transposed data values, the skipping of edge elements, the tile-level barrier counts, and that starts issued during a run are ignored. To show these, the bench replays ragged matrix shapes under random ready stalls against an independently generated beat list.

// File: rtl/tte_pkg.sv
package tte_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } tte_state_e;
endpackage

// File: rtl/tte_tile_buf.sv
module tte_tile_buf #(
  parameter int DATA_W    = 32,
  parameter int TILE_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [TILE_LOG2-1:0] wr_row,
  input  logic [TILE_LOG2-1:0] wr_col,
  input  logic [DATA_W-1:0]    wr_word,
  input  logic [TILE_LOG2-1:0] rd_row,
  input  logic [TILE_LOG2-1:0] rd_col,
  output logic [DATA_W-1:0]    rd_word
);
  localparam int SIDE  = 1 << TILE_LOG2;
  localparam int DEPTH = SIDE * SIDE;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[{wr_row, wr_col}] <= wr_word;
    end
  end

  assign rd_word = cells[{rd_row, rd_col}];
endmodule

// File: rtl/tte_index_walk.sv
module tte_index_walk #(
  parameter int DIM_W     = 10,
  parameter int TILE_LOG2 = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       step,
  input  logic                       adv_tile,
  input  logic [DIM_W-TILE_LOG2-1:0] last_tr,
  input  logic [DIM_W-TILE_LOG2-1:0] last_tc,
  output logic [TILE_LOG2-1:0]       ex,
  output logic [TILE_LOG2-1:0]       ey,
  output logic [DIM_W-TILE_LOG2-1:0] tr,
  output logic [DIM_W-TILE_LOG2-1:0] tc,
  output logic                       tile_end,
  output logic                       grid_end
);
  localparam int TIDX_W = DIM_W - TILE_LOG2;
  localparam logic [TILE_LOG2-1:0] EMAX = '1;

  logic [TILE_LOG2-1:0] ex_n, ey_n;
  logic [TIDX_W-1:0]    tr_n, tc_n;

  assign tile_end = (ex == EMAX) && (ey == EMAX);
  assign grid_end = (tr == last_tr) && (tc == last_tc);

  always_comb begin
    ex_n = ex;
    ey_n = ey;
    tr_n = tr;
    tc_n = tc;
    if (clear) begin
      ex_n = '0;
      ey_n = '0;
      tr_n = '0;
      tc_n = '0;
    end else begin
      if (step) begin
        ex_n = ex + 1'b1;
        if (ex == EMAX) begin
          ey_n = ey + 1'b1;
        end
      end
      if (adv_tile) begin
        if (tc == last_tc) begin
          tc_n = '0;
          tr_n = tr + 1'b1;
        end else begin
          tc_n = tc + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex <= '0;
      ey <= '0;
      tr <= '0;
      tc <= '0;
    end else if (clear || step) begin
      ex <= ex_n;
      ey <= ey_n;
      tr <= tr_n;
      tc <= tc_n;
    end
  end
endmodule

// File: rtl/tte_addr_gen.sv
module tte_addr_gen #(
  parameter int DIM_W     = 10,
  parameter int ADDR_W    = 20,
  parameter int TILE_LOG2 = 5
) (
  input  logic [DIM_W-TILE_LOG2-1:0] tile_row,
  input  logic [DIM_W-TILE_LOG2-1:0] tile_col,
  input  logic [TILE_LOG2-1:0]       elem_row,
  input  logic [TILE_LOG2-1:0]       elem_col,
  input  logic [DIM_W-1:0]           row_lim,
  input  logic [DIM_W-1:0]           col_lim,
  input  logic [DIM_W-1:0]           stride,
  input  logic [ADDR_W-1:0]          base,
  output logic [ADDR_W-1:0]          addr,
  output logic                       in_range
);
  logic [DIM_W-1:0] row, col;

  assign row      = {tile_row, elem_row};
  assign col      = {tile_col, elem_col};
  assign in_range = (row < row_lim) && (col < col_lim);
  assign addr     = base + ADDR_W'(row) * ADDR_W'(stride) + ADDR_W'(col);
endmodule

// File: rtl/tile_transpose_engine.sv
module tile_transpose_engine #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 20,
  parameter int DIM_W     = 10,
  parameter int TILE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import tte_pkg::*;

  localparam int TIDX_W = DIM_W - TILE_LOG2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  tte_state_e        state_q, state_n;
  logic [DIM_W-1:0]  w_q, h_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [TIDX_W-1:0] last_tr_q, last_tc_q;

  logic cfg_take, zero_dim;
  logic step, adv_tile, tile_end, grid_end;
  logic ld_in, st_in;
  logic [TILE_LOG2-1:0] ex, ey;
  logic [TIDX_W-1:0]    tr, tc;
  logic [ADDR_W-1:0]    ld_addr, st_addr;
  logic [DATA_W-1:0]    buf_word;

  assign cfg_take = (state_q == ST_IDLE) && start;
  assign zero_dim = (cfg_width == '0) || (cfg_height == '0);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      w_q       <= '0;
      h_q       <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      last_tr_q <= '0;
      last_tc_q <= '0;
    end else if (cfg_take) begin
      w_q       <= cfg_width;
      h_q       <= cfg_height;
      src_q     <= cfg_src_base;
      dst_q     <= cfg_dst_base;
      last_tr_q <= TIDX_W'((cfg_height - 1'b1) >> TILE_LOG2);
      last_tc_q <= TIDX_W'((cfg_width - 1'b1) >> TILE_LOG2);
    end
  end

  always_comb begin
    step = 1'b0;
    if (state_q == ST_FILL) begin
      step = !ld_in || rd_ready;
    end else if (state_q == ST_DRAIN) begin
      step = !st_in || wr_ready;
    end
  end
  assign adv_tile = (state_q == ST_DRAIN) && step && tile_end;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_n = zero_dim ? ST_FIN : ST_FILL;
      ST_FILL:  if (step && tile_end) state_n = ST_DRAIN;
      ST_DRAIN: if (step && tile_end) state_n = grid_end ? ST_FIN : ST_FILL;
      ST_FIN:   state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  tte_index_walk #(.DIM_W(DIM_W), .TILE_LOG2(TILE_LOG2)) u_walk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (cfg_take),
    .step     (step),
    .adv_tile (adv_tile),
    .last_tr  (last_tr_q),
    .last_tc  (last_tc_q),
    .ex       (ex),
    .ey       (ey),
    .tr       (tr),
    .tc       (tc),
    .tile_end (tile_end),
    .grid_end (grid_end)
  );

  // fill: source row tr*T+ey, column tc*T+ex
  tte_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .TILE_LOG2(TILE_LOG2)) u_ld_addr (
    .tile_row (tr),
    .tile_col (tc),
    .elem_row (ey),
    .elem_col (ex),
    .row_lim  (h_q),
    .col_lim  (w_q),
    .stride   (w_q),
    .base     (src_q),
    .addr     (ld_addr),
    .in_range (ld_in)
  );

  // drain: tile indices swapped, destination rows are source columns
  tte_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .TILE_LOG2(TILE_LOG2)) u_st_addr (
    .tile_row (tc),
    .tile_col (tr),
    .elem_row (ey),
    .elem_col (ex),
    .row_lim  (w_q),
    .col_lim  (h_q),
    .stride   (h_q),
    .base     (dst_q),
    .addr     (st_addr),
    .in_range (st_in)
  );

  tte_tile_buf #(.DATA_W(DATA_W), .TILE_LOG2(TILE_LOG2)) u_buf (
    .clk     (clk),
    .wr_en   ((state_q == ST_FILL) && ld_in && rd_ready),
    .wr_row  (ey),
    .wr_col  (ex),
    .wr_word (rd_data),
    .rd_row  (ex),
    .rd_col  (ey),
    .rd_word (buf_word)
  );

  assign rd_valid = (state_q == ST_FILL) && ld_in;
  assign rd_addr  = ld_addr;
  assign wr_valid = (state_q == ST_DRAIN) && st_in;
  assign wr_addr  = st_addr;
  assign wr_data  = buf_word;
  assign busy     = (state_q == ST_FILL) || (state_q == ST_DRAIN);
  assign done     = (state_q == ST_FIN);
endmodule

// File: rtl/tte_checker.sv
module tte_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] src_q,
  input logic [DIM_W-1:0]  w_q,
  input logic [DIM_W-1:0]  h_q
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7
  AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid); // R10
  AST_RD_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr - src_q) < (ADDR_W'(w_q) * ADDR_W'(h_q))); // R2
endmodule

bind tile_transpose_engine tte_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_tte_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .src_q    (src_q),
  .w_q      (w_q),
  .h_q      (h_q)
);

// File: tb/test_tile_transpose_engine.sv
module test_tile_transpose_engine;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 20;
  localparam int DIM_W  = 10;
  localparam int T      = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0;
  logic [ADDR_W-1:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic busy, done, rd_valid, wr_valid;
  logic rd_ready = 1'b0, wr_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] src_word(input int a);
    logic [ADDR_W-1:0] aa;
    aa = ADDR_W'(a);
    return (32'(aa) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  assign rd_data = src_word(int'(rd_addr));

  tile_transpose_engine i_tile_transpose_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  int exp_ra[$], exp_rbar[$];
  int exp_wa[$], exp_wbar[$];
  logic [DATA_W-1:0] exp_wd[$];
  logic [DATA_W-1:0] dst_mem [int];
  int rd_seen = 0, wr_seen = 0, done_cnt = 0;
  int stall_pct = 0;
  logic prev_rv = 0, prev_rr = 0, prev_wv = 0, prev_wr = 0;
  logic [ADDR_W-1:0] prev_ra = '0, prev_wa = '0;
  logic [DATA_W-1:0] prev_wd = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference beat lists from the requirements (R2, R3, R4, R5)
  task automatic build(input int w, input int h, input int src, input int dst);
    int rcount, wcount, ntr, ntc;
    exp_ra.delete(); exp_rbar.delete();
    exp_wa.delete(); exp_wbar.delete(); exp_wd.delete();
    rcount = 0; wcount = 0;
    ntr = (h + T - 1) / T;
    ntc = (w + T - 1) / T;
    for (int tr = 0; tr < ntr; tr++) begin
      for (int tc = 0; tc < ntc; tc++) begin
        for (int j = 0; j < T; j++) begin
          for (int i = 0; i < T; i++) begin
            int y, x;
            y = tr * T + j; x = tc * T + i;
            if (x < w && y < h) begin
              exp_ra.push_back((src + y * w + x) % (1 << ADDR_W));
              exp_rbar.push_back(wcount);
              rcount++;
            end
          end
        end
        for (int j = 0; j < T; j++) begin
          for (int i = 0; i < T; i++) begin
            int y, x;
            y = tc * T + j; x = tr * T + i;
            if (x < h && y < w) begin
              exp_wa.push_back((dst + y * h + x) % (1 << ADDR_W));
              exp_wd.push_back(src_word(src + x * w + y));
              exp_wbar.push_back(rcount);
              wcount++;
            end
          end
        end
      end
    end
  endtask

  // per-clock monitor: drives readies, compares every beat
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        rd_ready = ($urandom_range(99) >= stall_pct);
        wr_ready = ($urandom_range(99) >= stall_pct);
        if (prev_rv && !prev_rr)
          check(rd_valid && rd_addr == prev_ra, "R6", "read held", rd_addr, prev_ra);
        if (prev_wv && !prev_wr)
          check(wr_valid && wr_addr == prev_wa && wr_data == prev_wd, "R6", "write held",
                wr_addr, prev_wa);
        if (!busy) check(!rd_valid && !wr_valid, "R10", "valid while idle",
                         {rd_valid, wr_valid}, 0);
        if (rd_valid && rd_ready) begin
          if (exp_ra.size() == 0) begin
            check(0, "R2", "unexpected read", rd_addr, 0);
          end else begin
            check(rd_addr == ADDR_W'(exp_ra[0]), "R2", "read addr", rd_addr, exp_ra[0]);
            check(wr_seen == exp_rbar[0], "R4", "writes before read", wr_seen, exp_rbar[0]);
            void'(exp_ra.pop_front()); void'(exp_rbar.pop_front());
          end
          rd_seen++;
        end
        if (wr_valid && wr_ready) begin
          if (exp_wa.size() == 0) begin
            check(0, "R3", "unexpected write", wr_addr, 0);
          end else begin
            check(wr_addr == ADDR_W'(exp_wa[0]), "R3", "write addr", wr_addr, exp_wa[0]);
            check(wr_data == exp_wd[0], "R3", "write data", wr_data, exp_wd[0]);
            check(rd_seen == exp_wbar[0], "R4", "reads before write", rd_seen, exp_wbar[0]);
            void'(exp_wa.pop_front()); void'(exp_wd.pop_front()); void'(exp_wbar.pop_front());
          end
          dst_mem[int'(wr_addr)] = wr_data;
          wr_seen++;
        end
        if (done) begin
          done_cnt++;
          check(exp_ra.size() == 0 && exp_wa.size() == 0, "R7", "beats left at done",
                exp_ra.size() + exp_wa.size(), 0);
        end
        prev_rv = rd_valid; prev_rr = rd_ready; prev_ra = rd_addr;
        prev_wv = wr_valid; prev_wr = wr_ready; prev_wa = wr_addr; prev_wd = wr_data;
      end
    end
  end

  task automatic run_case(input int w, input int h, input int src, input int dst,
                          input int stall, input bit poke, input string name);
    int d0, cyc;
    build(w, h, src, dst);
    dst_mem.delete();
    rd_seen = 0; wr_seen = 0;
    stall_pct = stall;
    d0 = done_cnt;
    @(negedge clk);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
    cfg_src_base = ADDR_W'(src); cfg_dst_base = ADDR_W'(dst);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_width = DIM_W'(w + 7); cfg_height = DIM_W'(h + 3);  // R8: later changes ignored
    cfg_src_base = ADDR_W'(src + 11);
    cyc = 0;
    while (done_cnt == d0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) start = 1'b1;   // R8: start during run ignored
      if (poke && cyc == 41) start = 1'b0;
    end
    check(done_cnt == d0 + 1, "R7", {name, " done pulse count"}, done_cnt - d0, 1);
    @(negedge clk);
    check(!busy && !done, "R7", {name, " idle after done"}, {busy, done}, 0);
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, "R8", {name, " no extra run"}, done_cnt - d0, 1);
    check(exp_ra.size() == 0 && exp_wa.size() == 0, "R5", {name, " all beats seen"},
          exp_ra.size() + exp_wa.size(), 0);
    if (w == 0 || h == 0)
      check(rd_seen == 0 && wr_seen == 0, "R9", {name, " no beats"}, rd_seen + wr_seen, 0);
    for (int r = 0; r < w; r++) begin
      for (int c = 0; c < h; c++) begin
        int a;
        logic [DATA_W-1:0] e;
        a = (dst + r * h + c) % (1 << ADDR_W);
        e = src_word(src + c * w + r);
        check(dst_mem.exists(a) && dst_mem[a] == e, "R3", {name, " result"},
              dst_mem.exists(a) ? dst_mem[a] : 0, e);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_valid && !wr_valid, "R1", "reset outputs",
          {busy, done, rd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !rd_valid && !wr_valid, "R1", "outputs after release",
          {busy, done, rd_valid, wr_valid}, 0);
    run_case(5, 3, 100, 5000, 0, 0, "small");
    run_case(32, 32, 0, 2000, 30, 0, "full tile");
    run_case(40, 35, 17, 9000, 25, 1, "ragged 2x2");
    run_case(70, 20, 300, 20000, 10, 0, "wide 1x3");
    run_case(3, 66, 50, 40000, 20, 0, "tall 3x1");
    run_case(0, 7, 10, 600, 0, 0, "zero width");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule